// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host side of a link to a serial delta-sigma converter whose single data output also serves as an active-low "conversion finished" flag. The reader drives the converter's chip select and serial clock. After a start request it pulls chip select low and watches the shared line. When the line drops low, a result is ready, and the reader runs a burst of serial clock cycles to shift in one 24-bit word, most significant bit first. It then presents the word as two overload flags and a signed 22-bit value, along with a single-cycle valid strobe.

The serial clock rate is set at run time as a half-period count in system clocks. A mode input picks the level the clock rests at while the link is idle: low for SPI mode 0,0 or high for SPI mode 1,1. The converter updates its line on falling clock edges, so the reader samples on rising edges. If no ready indication appears within a fixed number of cycles, the wait is abandoned, chip select is released, and an error flag is raised.

Top module: `dsr_reader`

## Requirements
- R1: During and after reset, with no transaction running, `cs_n` is high, `busy`, `res_valid` and `err_timeout` are low, and `sclk` rests at the level of `idle_high` (1 = rests high, 0 = rests low), following it one cycle later.
- R2: A `start` pulse while idle drives `cs_n` low and `busy` high on the next clock edge.
- R3: While `cs_n` is low and the converter line is still high (not ready), `sclk` stays at its idle level.
- R4: During the burst every `sclk` period lasts exactly 2*max(`half_div`,1) system clock cycles, so a `half_div` of 0 acts as 1.
- R5: Bits are sampled from `sdo_rdy` on rising `sclk` edges, most significant first, and exactly 24 rising edges are sampled per word.
- R6: With `idle_high`=1 the first clock edge after ready is a falling edge. With `idle_high`=0 the reader first gives one unsampled rising edge, so 25 rising edges appear while `cs_n` is low.
- R7: Received bit 23 appears on `res_ovf_hi`, bit 22 on `res_ovf_lo`, and bits 21..0 on `res_data` as a two's-complement value.
- R8: After the last sampled bit, `sclk` returns to its idle level. One cycle later `cs_n` rises together with a one-cycle `res_valid` pulse. The result outputs then hold their values until the next pulse.
- R9: If the line stays high for TIMEOUT_CYC cycles after `cs_n` falls, `cs_n` rises with no clock burst and no `res_valid`, and `err_timeout` goes high. It stays high until the next accepted start clears it.
- R10: A `start` that arrives while `busy` is high is ignored, and no second transaction follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one read transaction |
| idle_high | input | 1 | Serial clock idle level: 1 high (mode 1,1), 0 low (mode 0,0) |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| sdo_rdy | input | 1 | Shared converter data / active-low ready line |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A transaction is in progress |
| res_valid | output | 1 | One-cycle strobe: new result on the outputs |
| res_ovf_hi | output | 1 | Overload flag from received bit 23 |
| res_ovf_lo | output | 1 | Overload flag from received bit 22 |
| res_data | output | WORD_W-2 | Two's-complement conversion value |
| err_timeout | output | 1 | Ready wait expired; cleared by next accepted start |

## Verification
Chip select and busy respond on the first edge after a start, so the bench checks them at the following falling edge. A result is due one cycle after the clock returns to idle. Its arrival time depends on the random ready delay and the clock divide, so the bench polls `res_valid` at falling edges and then checks the flags, the data and `cs_n` in that same cycle, and checks that the strobe is gone one cycle later. Clock periods, edge order and the count of rising edges are timestamped by monitors on `sclk` itself. The timeout case counts falling system-clock edges with chip select low and compares the total against TIMEOUT_CYC exactly.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } dsr_state_e;

  localparam int unsigned FLAG_W = 2;

endpackage

// File: rtl/dsr_sclk_div.sv
module dsr_sclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a half period below one system clock is not possible
  assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick = run && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/dsr_shift_in.sv
module dsr_shift_in #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         cap,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         full
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(W));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word <= '0;
      cnt  <= '0;
    end else if (cap) begin
      word <= {word[W-2:0], din};
      cnt  <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/dsr_wait_timer.sv
module dsr_wait_timer #(
  parameter int unsigned LIM = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);

  localparam int unsigned TW = (LIM > 1) ? $clog2(LIM) : 1;

  logic [TW-1:0] cnt;

  assign expired = en && (cnt == TW'(LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + TW'(1);
    end
  end

endmodule

// File: rtl/dsr_reader.sv
module dsr_reader
  import dsr_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 1048576
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     idle_high,
  input  logic [DIV_W-1:0]         half_div,
  input  logic                     sdo_rdy,
  output logic                     cs_n,
  output logic                     sclk,
  output logic                     busy,
  output logic                     res_valid,
  output logic                     res_ovf_hi,
  output logic                     res_ovf_lo,
  output logic [WORD_W-FLAG_W-1:0] res_data,
  output logic                     err_timeout
);

  localparam int unsigned DATA_W = WORD_W - FLAG_W;

  dsr_state_e        st;
  logic              mode_hi;
  logic              tick;
  logic              run_div;
  logic              sh_clear;
  logic              sh_cap;
  logic              sh_full;
  logic [WORD_W-1:0] sh_word;
  logic              tmo_hit;

  assign run_div  = (st == ST_LEAD) || (st == ST_LOW) || (st == ST_HIGH);
  assign sh_clear = (st == ST_IDLE);
  assign sh_cap   = (st == ST_LOW) && tick;
  assign busy     = (st != ST_IDLE);

  dsr_sclk_div #(.DIV_W(DIV_W)) i_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run_div),
    .half_div (half_div),
    .tick     (tick)
  );

  dsr_shift_in #(.W(WORD_W)) i_shift (
    .clk   (clk),
    .rst   (rst),
    .clear (sh_clear),
    .cap   (sh_cap),
    .din   (sdo_rdy),
    .word  (sh_word),
    .full  (sh_full)
  );

  dsr_wait_timer #(.LIM(TIMEOUT_CYC)) i_tmo (
    .clk     (clk),
    .rst     (rst),
    .en      (st == ST_WAIT),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mode_hi     <= 1'b0;
      cs_n        <= 1'b1;
      sclk        <= idle_high;
      res_valid   <= 1'b0;
      res_ovf_hi  <= 1'b0;
      res_ovf_lo  <= 1'b0;
      res_data    <= '0;
      err_timeout <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          sclk <= idle_high;
          if (start) begin
            st          <= ST_WAIT;
            mode_hi     <= idle_high;
            cs_n        <= 1'b0;
            err_timeout <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (!sdo_rdy) begin
            // resting high: first edge falls; resting low: one dummy rise first
            st   <= mode_hi ? ST_LOW : ST_LEAD;
            sclk <= !mode_hi;
          end else if (tmo_hit) begin
            st          <= ST_IDLE;
            cs_n        <= 1'b1;
            err_timeout <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            st   <= ST_LOW;
            sclk <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tick) begin
            st   <= ST_HIGH;
            sclk <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (sh_full) begin
              st   <= ST_DONE;
              sclk <= mode_hi;
            end else begin
              st   <= ST_LOW;
              sclk <= 1'b0;
            end
          end
        end
        ST_DONE: begin
          st         <= ST_IDLE;
          cs_n       <= 1'b1;
          res_valid  <= 1'b1;
          res_ovf_hi <= sh_word[WORD_W-1];
          res_ovf_lo <= sh_word[WORD_W-2];
          res_data   <= sh_word[DATA_W-1:0];
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsr_reader_chk.sv
module dsr_reader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic idle_high,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic res_valid,
  input logic err_timeout
);

  // R1
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R1
  idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == $past(idle_high)));

  // R2
  start_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (!cs_n && busy));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8
  valid_cs_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(cs_n));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> ($rose(cs_n) && !res_valid));

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (res_valid || $rose(err_timeout)));

endmodule

bind dsr_reader dsr_reader_chk i_dsr_reader_chk (.*);

// File: tb/test_dsr_reader.sv
`timescale 1ns/1ps
module test_dsr_reader;

  localparam int TMO = 300;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          idle_high = 1'b0;
  logic [DW-1:0] half_div = 8'd1;
  logic          sdo_rdy;
  logic          cs_n, sclk, busy, res_valid, res_ovf_hi, res_ovf_lo, err_timeout;
  logic [21:0]   res_data;

  always #10 clk = ~clk;

  dsr_reader #(.WORD_W(24), .DIV_W(DW), .TIMEOUT_CYC(TMO)) i_dsr_reader (
    .clk(clk), .rst(rst), .start(start), .idle_high(idle_high),
    .half_div(half_div), .sdo_rdy(sdo_rdy), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .res_valid(res_valid), .res_ovf_hi(res_ovf_hi),
    .res_ovf_lo(res_ovf_lo), .res_data(res_data), .err_timeout(err_timeout)
  );

  // converter model
  logic [23:0] m_pat = '0;
  int          m_delay = 0;
  int          m_cnt = 0;
  logic        m_rdy = 1'b0;
  int          m_falls = 0;
  int          m_base = 0;
  int          nf;

  always @(negedge sclk) m_falls++;

  always @(posedge clk) begin
    if (cs_n) begin
      m_rdy <= 1'b0;
      m_cnt <= 0;
    end else if (!m_rdy) begin
      if (m_cnt >= m_delay) begin
        m_rdy  <= 1'b1;
        m_base <= m_falls;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  always_comb begin
    nf = m_falls - m_base;
    if (cs_n || !m_rdy)          sdo_rdy = 1'b1;
    else if (nf == 0)            sdo_rdy = 1'b0;
    else if (nf >= 1 && nf <= 24) sdo_rdy = m_pat[24-nf];
    else                         sdo_rdy = 1'b1;
  end

  // monitors
  int   n_rise, per_bad, cs_low_cnt, wait_bad, valid_cnt;
  time  last_rise, exp_per;
  bit   first_set, first_rise;
  logic mode_exp;

  always @(posedge sclk) if (!cs_n) begin
    if (n_rise > 0 && ($time - last_rise) != exp_per) per_bad++;
    last_rise = $time;
    n_rise++;
  end

  always @(sclk) if (!cs_n && !first_set) begin
    first_set  = 1'b1;
    first_rise = sclk;
  end

  always @(negedge clk) begin
    if (!cs_n) cs_low_cnt++;
    if (!cs_n && !m_rdy && sclk !== mode_exp) wait_bad++;
    if (res_valid) valid_cnt++;
  end

  // bookkeeping
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "WATCHDOG", "cycles", cyc, 0);
      finish_run();
    end
  end

  function automatic int exp_val(input logic [23:0] p);
    int v;
    v = $signed(p[21:0]);
    return v;
  endfunction

  task automatic clear_mon(input int half, input bit ih);
    n_rise = 0; per_bad = 0; cs_low_cnt = 0; wait_bad = 0; valid_cnt = 0;
    first_set = 1'b0; first_rise = 1'b0;
    exp_per = 2 * ((half == 0) ? 1 : half) * 20;
    mode_exp = ih;
  endtask

  task automatic txn(input logic [23:0] pat, input int dly, input int half,
                     input bit ih, input bit poke);
    bit   seen;
    logic h_hi, h_lo;
    logic [21:0] h_d;
    int got;
    idle_high = ih;
    half_div  = DW'(half);
    m_pat     = pat;
    m_delay   = dly;
    repeat (3) @(negedge clk);
    clear_mon(half, ih);
    check(sclk === ih && cs_n === 1'b1, "R1", "idle sclk", sclk, ih);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cs_n === 1'b0 && busy === 1'b1, "R2", "cs_n after start", cs_n, 0);
    check(err_timeout === 1'b0, "R9", "err cleared by start", err_timeout, 0);
    seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      if (poke && i == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      if (res_valid === 1'b1) seen = 1'b1;
    end
    start = 1'b0;
    check(seen, "R8", "valid seen", seen, 1);
    check(cs_n === 1'b1, "R8", "cs_n with valid", cs_n, 1);
    check(res_ovf_hi === pat[23], "R7", "ovf_hi", res_ovf_hi, pat[23]);
    check(res_ovf_lo === pat[22], "R7", "ovf_lo", res_ovf_lo, pat[22]);
    got = $signed(res_data);
    check(got == exp_val(pat), "R5", "data", got, exp_val(pat));
    check(n_rise == (ih ? 24 : 25), "R6", "rising edges", n_rise, ih ? 24 : 25);
    check(per_bad == 0, "R4", "sclk period errors", per_bad, 0);
    check(first_rise == !ih, "R6", "first edge is rise", first_rise, !ih);
    check(wait_bad == 0, "R3", "sclk moved while waiting", wait_bad, 0);
    h_hi = res_ovf_hi; h_lo = res_ovf_lo; h_d = res_data;
    @(negedge clk);
    check(res_valid === 1'b0, "R8", "valid width", res_valid, 0);
    repeat (6) @(negedge clk);
    check(res_data === h_d && res_ovf_hi === h_hi && res_ovf_lo === h_lo,
          "R8", "result held", res_data, h_d);
    check(busy === 1'b0 && cs_n === 1'b1 && valid_cnt == 1, "R10",
          "no extra transaction", valid_cnt, 1);
  endtask

  task automatic tmo_txn(input bit ih);
    bit seen;
    idle_high = ih;
    half_div  = DW'(2);
    m_delay   = 1000000;
    repeat (3) @(negedge clk);
    clear_mon(2, ih);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < TMO + 50 && !seen; i++) begin
      @(negedge clk);
      if (err_timeout === 1'b1) seen = 1'b1;
    end
    check(seen, "R9", "timeout flag", seen, 1);
    check(cs_low_cnt == TMO, "R9", "cs low cycles", cs_low_cnt, TMO);
    check(cs_n === 1'b1 && busy === 1'b0, "R9", "released", cs_n, 1);
    check(valid_cnt == 0 && n_rise == 0, "R9", "no burst/valid", n_rise, 0);
    repeat (5) @(negedge clk);
    check(err_timeout === 1'b1, "R9", "flag holds", err_timeout, 1);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    check(cs_n === 1'b1 && busy === 1'b0 && res_valid === 1'b0 && err_timeout === 1'b0,
          "R1", "reset state", cs_n, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk === idle_high, "R1", "sclk after reset", sclk, idle_high);
    // directed corners
    txn(24'h800000, 3, 1, 1'b1, 1'b0);
    txn(24'h400000, 0, 2, 1'b0, 1'b0);
    txn(24'hC00000, 5, 0, 1'b1, 1'b0);
    txn(24'h3FFFFF, 7, 3, 1'b0, 1'b1);
    txn(24'h200000, 12, 1, 1'b0, 1'b0);
    txn(24'hFFFFFF, 1, 2, 1'b1, 1'b1);
    txn(24'h000000, 2, 1, 1'b0, 1'b0);
    tmo_txn(1'b1);
    txn(24'h155555, 4, 1, 1'b1, 1'b0);
    tmo_txn(1'b0);
    // constrained random
    for (int k = 0; k < 10; k++) begin
      txn(24'($urandom), int'($urandom_range(40, 0)), int'($urandom_range(4, 0)),
          1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end
    finish_run();
  end

endmodule